// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Flags

A first-in first-out buffer for 9-bit words whose write side and read side each run on their own clock. The two clocks may be one net or fully unrelated. Each port is qualified by a pair of enables. The write pair is one active-low enable and one active-high enable. The read pair is two active-low enables. A word moves only when both enables of a pair are asserted.

Besides the exact Empty and Full flags, the block raises an Almost-Empty flag and an Almost-Full flag. Their thresholds sit in two offset registers. While the load strobe is high, enabled write cycles load these registers from the data input instead of storing data. Both offsets come back to 7 on reset. An output-enable input gates the read data bus. When disabled, the bus reads as zero and a valid bit drops. This is the synthesizable stand-in for a three-state bus.

Top module: `prog_flag_fifo`

## Requirements
- R1: A word is stored at a write-clock rising edge only when wen_n_i is 0, wen_i is 1, load_i is 0 and the FIFO is not full. Any other combination of the two write enables stores nothing. Words are read back in the order they were written.
- R2: A read is accepted at a read-clock rising edge only when ren1_n_i and ren2_n_i are both 0 and the FIFO is not empty. The word appears on the registered read data at that edge, one read-clock cycle after the request. Without an accepted read, the read data holds its value.
- R3: A write attempted while full is ignored. The stored words and the write pointer are unchanged, so later reads return the original contents.
- R4: A read attempted while empty is ignored. The read pointer and the read data are unchanged.
- R5: empty_o is 1 exactly when the read side sees zero words stored. full_o is 1 exactly when the write side sees DEPTH words stored. After activity on the other port, each flag settles within three cycles of its own clock.
- R6: almost_empty_o is 1 when the stored word count is less than or equal to the Almost-Empty offset. The offset is 7 unless reprogrammed.
- R7: almost_full_o is 1 when the stored word count is greater than or equal to DEPTH minus the Almost-Full offset. The offset is 7 unless reprogrammed.
- R8: Each write cycle with load_i at 1 and both write enables asserted loads din_i, zero-extended or truncated to log2(DEPTH) bits, into an offset register instead of the array. The offsets are taken alternately, Almost-Empty first after reset and then Almost-Full. Stored data and the write pointer are unchanged.
- R9: rst_ni at 0 clears both pointers and the read data. It sets empty_o and almost_empty_o to 1 and full_o and almost_full_o to 0. It reloads both offsets with 7 and restarts the load alternation at Almost-Empty.
- R10: With oe_n_i at 1, dout_o is all zeros and dout_vld_o is 0. With oe_n_i at 0, dout_vld_o is 1 and dout_o shows the registered read data. The output enable alters neither the stored words nor the read data register.
- R11: Each pointer crosses to the other clock domain as a Gray code that changes in at most one bit per clock. The FIFO passes data in order with no loss when the two clocks are unrelated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous active-low reset of both sides |
| wen_n_i | input | 1 | Write enable, active low |
| wen_i | input | 1 | Write enable, active high |
| load_i | input | 1 | Steers enabled write cycles into the offset registers |
| din_i | input | 9 | Write data or offset value |
| ren1_n_i | input | 1 | First read enable, active low |
| ren2_n_i | input | 1 | Second read enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| dout_o | output | 9 | Gated read data |
| dout_vld_o | output | 1 | Read data bus is enabled |
| empty_o | output | 1 | No words stored (read domain) |
| full_o | output | 1 | DEPTH words stored (write domain) |
| almost_empty_o | output | 1 | Count at or below the Almost-Empty offset |
| almost_full_o | output | 1 | Count at or above DEPTH minus the Almost-Full offset |

## Verification
A write and a read can be accepted in the same clock cycle. Each then moves its own pointer while the other pointer is in flight through the synchronizers. The bench provokes this with both clocks tied: it holds the FIFO at a middle fill level and raises both enable pairs in the same cycle over a run of words. Each returned word must match the one written that many writes earlier. After settling, the four flags must still match the unchanged count. A second run with unrelated clock periods streams words through with both sides busy and checks every word in order.

// File: rtl/prog_flag_fifo_pkg.sv
package prog_flag_fifo_pkg;
  localparam int DATA_W      = 9;
  localparam int OFF_DEFAULT = 7;

  typedef enum logic {
    OFF_SEL_AE = 1'b0,
    OFF_SEL_AF = 1'b1
  } off_sel_e;
endpackage

// File: rtl/pff_ptr_sync.sv
module pff_ptr_sync #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/pff_ram.sv
module pff_ram #(
  parameter int AW = 8,
  parameter int DW = 9
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge wclk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= mem[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/pff_wr_ctrl.sv
module pff_wr_ctrl
  import prog_flag_fifo_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wen_n_i,
  input  logic          wen_i,
  input  logic          load_i,
  input  logic [DW-1:0] din_i,
  input  logic [AW:0]   rgray_s_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0]   wbin_o,
  output logic [AW:0]   wgray_o,
  output logic          full_o,
  output logic          almost_full_o,
  output logic [AW-1:0] ae_off_o
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(1 << AW);

  logic [PW-1:0] wbin_q, wgray_q, wbin_nxt, rbin_s, count;
  logic [AW-1:0] ae_off_q, af_off_q, load_val;
  off_sel_e      sel_q;
  logic          wen_ok, load_fire, wr_fire;

  always_comb begin
    rbin_s[PW-1] = rgray_s_i[PW-1];
    for (int i = PW - 2; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_s_i[i];
  end

  assign count         = wbin_q - rbin_s;
  assign full_o        = (count == DEPTH_P);
  assign almost_full_o = (count >= (DEPTH_P - {1'b0, af_off_q}));

  assign wen_ok    = !wen_n_i && wen_i;
  assign load_fire = wen_ok && load_i;
  assign wr_fire   = wen_ok && !load_i && !full_o;
  assign wbin_nxt  = wbin_q + PW'(wr_fire);
  assign load_val  = AW'(din_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_nxt;
      wgray_q <= wbin_nxt ^ (wbin_nxt >> 1);
    end
  end

  // offsets: alternate AE/AF on each enabled load cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ae_off_q <= AW'(OFF_DEFAULT);
      af_off_q <= AW'(OFF_DEFAULT);
      sel_q    <= OFF_SEL_AE;
    end else if (load_fire) begin
      if (sel_q == OFF_SEL_AE) begin
        ae_off_q <= load_val;
        sel_q    <= OFF_SEL_AF;
      end else begin
        af_off_q <= load_val;
        sel_q    <= OFF_SEL_AE;
      end
    end
  end

  assign we_o     = wr_fire;
  assign waddr_o  = wbin_q[AW-1:0];
  assign wbin_o   = wbin_q;
  assign wgray_o  = wgray_q;
  assign ae_off_o = ae_off_q;
endmodule

// File: rtl/pff_rd_ctrl.sv
module pff_rd_ctrl #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ren1_n_i,
  input  logic          ren2_n_i,
  input  logic [AW:0]   wgray_s_i,
  input  logic [AW-1:0] ae_off_i,
  output logic          re_o,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rbin_o,
  output logic [AW:0]   rgray_o,
  output logic          empty_o,
  output logic          almost_empty_o
);
  localparam int PW = AW + 1;

  logic [PW-1:0] rbin_q, rgray_q, rbin_nxt, wbin_s, count;
  logic          rd_fire;

  always_comb begin
    wbin_s[PW-1] = wgray_s_i[PW-1];
    for (int i = PW - 2; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wgray_s_i[i];
  end

  assign count          = wbin_s - rbin_q;
  assign empty_o        = (count == '0);
  assign almost_empty_o = (count <= {1'b0, ae_off_i});

  assign rd_fire  = !ren1_n_i && !ren2_n_i && !empty_o;
  assign rbin_nxt = rbin_q + PW'(rd_fire);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else begin
      rbin_q  <= rbin_nxt;
      rgray_q <= rbin_nxt ^ (rbin_nxt >> 1);
    end
  end

  assign re_o    = rd_fire;
  assign raddr_o = rbin_q[AW-1:0];
  assign rbin_o  = rbin_q;
  assign rgray_o = rgray_q;
endmodule

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo
  import prog_flag_fifo_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              wen_n_i,
  input  logic              wen_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              ren1_n_i,
  input  logic              ren2_n_i,
  input  logic              oe_n_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_vld_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              almost_empty_o,
  output logic              almost_full_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0]     wbin, wgray, rbin, rgray, wgray_s, rgray_s;
  logic [AW-1:0]     waddr, raddr, ae_off;
  logic              we, rd_en;
  logic [DATA_W-1:0] rdata_q;

  pff_wr_ctrl #(.AW(AW), .DW(DATA_W)) u_wr (
    .clk_i         (wclk_i),
    .rst_ni        (rst_ni),
    .wen_n_i       (wen_n_i),
    .wen_i         (wen_i),
    .load_i        (load_i),
    .din_i         (din_i),
    .rgray_s_i     (rgray_s),
    .we_o          (we),
    .waddr_o       (waddr),
    .wbin_o        (wbin),
    .wgray_o       (wgray),
    .full_o        (full_o),
    .almost_full_o (almost_full_o),
    .ae_off_o      (ae_off)
  );

  pff_rd_ctrl #(.AW(AW)) u_rd (
    .clk_i          (rclk_i),
    .rst_ni         (rst_ni),
    .ren1_n_i       (ren1_n_i),
    .ren2_n_i       (ren2_n_i),
    .wgray_s_i      (wgray_s),
    .ae_off_i       (ae_off),
    .re_o           (rd_en),
    .raddr_o        (raddr),
    .rbin_o         (rbin),
    .rgray_o        (rgray),
    .empty_o        (empty_o),
    .almost_empty_o (almost_empty_o)
  );

  pff_ptr_sync #(.W(PW)) u_w2r (
    .clk_i  (rclk_i),
    .rst_ni (rst_ni),
    .d_i    (wgray),
    .q_o    (wgray_s)
  );

  pff_ptr_sync #(.W(PW)) u_r2w (
    .clk_i  (wclk_i),
    .rst_ni (rst_ni),
    .d_i    (rgray),
    .q_o    (rgray_s)
  );

  pff_ram #(.AW(AW), .DW(DATA_W)) u_ram (
    .wclk_i  (wclk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (din_i),
    .rclk_i  (rclk_i),
    .rst_ni  (rst_ni),
    .re_i    (rd_en),
    .raddr_i (raddr),
    .rdata_o (rdata_q)
  );

  assign dout_vld_o = !oe_n_i;
  assign dout_o     = oe_n_i ? '0 : rdata_q;
endmodule

// File: rtl/prog_flag_fifo_chk.sv
module prog_flag_fifo_chk #(
  parameter int PW = 9,
  parameter int DW = 9
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          wen_n_i,
  input logic          wen_i,
  input logic          load_i,
  input logic          ren1_n_i,
  input logic          ren2_n_i,
  input logic          full_o,
  input logic          empty_o,
  input logic          almost_full_o,
  input logic          almost_empty_o,
  input logic [PW-1:0] wbin,
  input logic [PW-1:0] rbin,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rgray,
  input logic          rd_en,
  input logic [DW-1:0] rdata_q
);
  a_r3_no_overflow: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (full_o && !wen_n_i && wen_i) |=> $stable(wbin));

  a_r4_no_underflow: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (empty_o && !ren1_n_i && !ren2_n_i) |=> $stable(rbin));

  a_r8_load_no_store: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (load_i && !wen_n_i && wen_i) |=> $stable(wbin));

  a_r2_rdata_hold: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !rd_en |=> $stable(rdata_q));

  a_r11_wgray_step: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $onehot0(wgray ^ $past(wgray)));

  a_r11_rgray_step: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $onehot0(rgray ^ $past(rgray)));

  a_r7_full_in_af: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_o |-> almost_full_o);

  a_r6_empty_in_ae: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    empty_o |-> almost_empty_o);
endmodule

bind prog_flag_fifo prog_flag_fifo_chk #(.PW(PW), .DW(DATA_W)) u_chk (
  .wclk_i         (wclk_i),
  .rclk_i         (rclk_i),
  .rst_ni         (rst_ni),
  .wen_n_i        (wen_n_i),
  .wen_i          (wen_i),
  .load_i         (load_i),
  .ren1_n_i       (ren1_n_i),
  .ren2_n_i       (ren2_n_i),
  .full_o         (full_o),
  .empty_o        (empty_o),
  .almost_full_o  (almost_full_o),
  .almost_empty_o (almost_empty_o),
  .wbin           (wbin),
  .rbin           (rbin),
  .wgray          (wgray),
  .rgray          (rgray),
  .rd_en          (rd_en),
  .rdata_q        (rdata_q)
);

// File: tb/prog_flag_fifo_bench.sv
module prog_flag_fifo_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RCLK_ASYNC = 14;
  localparam int DEPTH      = 16;
  localparam int N_ASYNC    = 40;

  logic wclk = 1'b0, rclk_a = 1'b0, async_mode = 1'b0;
  logic rclk;
  logic rst_ni = 1'b0;
  logic wen_n = 1'b1, wen = 1'b0, load = 1'b0;
  logic [8:0] din = '0;
  logic ren1_n = 1'b1, ren2_n = 1'b1, oe_n = 1'b0;
  logic [8:0] dout;
  logic dout_vld, empty, full, aempty, afull;

  int n_checks = 0, n_fail = 0;
  logic [8:0] mq[$];
  logic [8:0] last_rd = '0;

  always #(CLK_PERIOD/2) wclk = ~wclk;
  always #(RCLK_ASYNC/2) rclk_a = ~rclk_a;
  assign rclk = async_mode ? rclk_a : wclk;

  prog_flag_fifo #(.DEPTH(DEPTH)) u_prog_flag_fifo (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_ni),
    .wen_n_i(wen_n), .wen_i(wen), .load_i(load), .din_i(din),
    .ren1_n_i(ren1_n), .ren2_n_i(ren2_n), .oe_n_i(oe_n),
    .dout_o(dout), .dout_vld_o(dout_vld), .empty_o(empty), .full_o(full),
    .almost_empty_o(aempty), .almost_full_o(afull)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge wclk);
  endtask

  task automatic do_reset();
    @(negedge wclk);
    rst_ni = 1'b0;
    settle(2);
    rst_ni = 1'b1;
    mq.delete();
    last_rd = '0;
    settle(1);
  endtask

  task automatic wr_cycle(input logic wn, input logic w, input logic ld, input logic [8:0] d);
    @(negedge wclk);
    wen_n = wn; wen = w; load = ld; din = d;
    @(negedge wclk);
    wen_n = 1'b1; wen = 1'b0; load = 1'b0;
  endtask

  task automatic push(input logic [8:0] d);
    wr_cycle(1'b0, 1'b1, 1'b0, d);
    if (mq.size() < DEPTH) mq.push_back(d);
  endtask

  // tied clocks: read data sampled one cycle after request
  task automatic rd_cycle(input logic r1, input logic r2, input string tag);
    @(negedge wclk);
    ren1_n = r1; ren2_n = r2;
    @(negedge wclk);
    ren1_n = 1'b1; ren2_n = 1'b1;
    if (!r1 && !r2 && mq.size() > 0) last_rd = mq.pop_front();
    check(dout == last_rd, tag, dout, last_rd);
  endtask

  task automatic chk_flags(input string tag, input int ae_th, input int af_th);
    int n;
    settle(5);
    n = mq.size();
    check(empty == (n == 0), {tag, " R5 empty"}, empty, n == 0);
    check(full == (n == DEPTH), {tag, " R5 full"}, full, n == DEPTH);
    check(aempty == (n <= ae_th), {tag, " R6 almost_empty"}, aempty, n <= ae_th);
    check(afull == (n >= DEPTH - af_th), {tag, " R7 almost_full"}, afull, n >= DEPTH - af_th);
  endtask

  function automatic logic [8:0] pat(input int i);
    return 9'((i * 37 + 11) & 9'h1ff);
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    settle(3);
    rst_ni = 1'b1;
    settle(2);
    // R9 reset state
    check(empty == 1'b1, "R9 empty after reset", empty, 1);
    check(aempty == 1'b1, "R9 almost_empty after reset", aempty, 1);
    check(full == 1'b0, "R9 full after reset", full, 0);
    check(afull == 1'b0, "R9 almost_full after reset", afull, 0);
    check(dout == 9'd0, "R9 dout after reset", dout, 0);
    check(dout_vld == 1'b1, "R10 valid with oe_n low", dout_vld, 1);

    // R1 disabled enable combinations store nothing
    wr_cycle(1'b1, 1'b1, 1'b0, 9'h0AA);
    wr_cycle(1'b0, 1'b0, 1'b0, 9'h0AB);
    wr_cycle(1'b1, 1'b0, 1'b0, 9'h0AC);
    chk_flags("R1 gated writes", 7, 7);

    // R5 R6 R7 sweep of every fill level with default offsets
    for (int i = 0; i < DEPTH; i++) begin
      push(pat(i));
      chk_flags($sformatf("fill %0d default", i + 1), 7, 7);
    end

    // R3 write while full
    push(9'h1FF);
    chk_flags("R3 write when full", 7, 7);

    // R2 gated reads do not move the pointer
    rd_cycle(1'b0, 1'b1, "R2 gated read hold");
    rd_cycle(1'b1, 1'b0, "R2 gated read hold");

    // R2 R3 drain in order, flags at each level
    for (int i = 0; i < DEPTH; i++) begin
      rd_cycle(1'b0, 1'b0, "R2 R3 read order");
      chk_flags($sformatf("drain %0d", i), 7, 7);
    end

    // R4 read while empty
    rd_cycle(1'b0, 1'b0, "R4 read when empty holds dout");
    chk_flags("R4 still empty", 7, 7);

    // R10 output enable gating
    @(negedge wclk); oe_n = 1'b1;
    @(negedge wclk);
    check(dout == 9'd0, "R10 dout forced zero", dout, 0);
    check(dout_vld == 1'b0, "R10 valid low", dout_vld, 0);
    oe_n = 1'b0;
    @(negedge wclk);
    check(dout == last_rd, "R10 data kept under oe", dout, last_rd);

    // R8 load sequence AE=3, AF=12, then AE=2
    wr_cycle(1'b0, 1'b1, 1'b1, 9'd3);
    wr_cycle(1'b0, 1'b1, 1'b1, 9'd12);
    wr_cycle(1'b0, 1'b1, 1'b1, 9'd2);
    wr_cycle(1'b1, 1'b1, 1'b1, 9'd9);  // gated: no load
    chk_flags("R8 load leaves array empty", 2, 12);
    for (int i = 0; i < DEPTH; i++) begin
      push(pat(i + 100));
      chk_flags($sformatf("R8 fill %0d programmed", i + 1), 2, 12);
    end
    for (int i = 0; i < DEPTH; i++) rd_cycle(1'b0, 1'b0, "R8 R1 read order");

    // same-cycle write and read at a middle fill level
    for (int i = 0; i < 6; i++) push(pat(i + 200));
    settle(5);
    for (int i = 0; i < 10; i++) begin
      @(negedge wclk);
      wen_n = 1'b0; wen = 1'b1; din = pat(i + 300);
      ren1_n = 1'b0; ren2_n = 1'b0;
      @(negedge wclk);
      wen_n = 1'b1; wen = 1'b0; ren1_n = 1'b1; ren2_n = 1'b1;
      mq.push_back(pat(i + 300));
      last_rd = mq.pop_front();
      check(dout == last_rd, "R1 R2 simultaneous word", dout, last_rd);
    end
    chk_flags("R5 simultaneous level", 2, 12);

    // R9 reset restores defaults and load order
    do_reset();
    chk_flags("R9 after reset", 7, 7);
    check(dout == 9'd0, "R9 dout cleared", dout, 0);
    for (int i = 0; i < 9; i++) begin
      push(pat(i + 400));
      chk_flags($sformatf("R9 default offsets fill %0d", i + 1), 7, 7);
    end
    wr_cycle(1'b0, 1'b1, 1'b1, 9'd1);  // first load after reset -> AE
    chk_flags("R9 load restarts at AE", 1, 7);

    // R11 unrelated clocks
    @(negedge wclk); rst_ni = 1'b0; async_mode = 1'b1;
    settle(3);
    rst_ni = 1'b1;
    mq.delete();
    settle(2);
    fork
      begin
        int k = 0;
        while (k < N_ASYNC) begin
          @(negedge wclk);
          if (!full) begin
            wen_n = 1'b0; wen = 1'b1; din = pat(k + 500); k++;
          end else begin
            wen_n = 1'b1; wen = 1'b0;
          end
        end
        @(negedge wclk);
        wen_n = 1'b1; wen = 1'b0;
      end
      begin
        int k = 0;
        bit pend = 1'b0;
        while (k < N_ASYNC) begin
          @(negedge rclk_a);
          if (pend) begin
            check(dout == pat(k + 500), "R11 async order", dout, pat(k + 500));
            k++;
          end
          pend = !empty && (k + 1 <= N_ASYNC) && (k < N_ASYNC);
          ren1_n = !pend; ren2_n = !pend;
        end
        ren1_n = 1'b1; ren2_n = 1'b1;
      end
    join
    repeat (6) @(negedge rclk_a);
    check(empty == 1'b1, "R11 R5 empty after stream", empty, 1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule